// File: doc/BRIEF.md
# Combinational Binary-to-BCD Converter

This block turns an unsigned binary word into three decimal digits with no clock and no iteration. It is a triangular array of identical divide-by-five cells. Each cell takes a 4-bit value no larger than nine. It returns one quotient bit and a remainder from zero to four. That remainder, moved up one place and joined with the next lower binary bit, feeds the next cell. A chain of such cells, with the word's least significant bit routed around it, divides the word by ten. The chain's quotient bits form the next binary value to convert, and its final remainder is a decimal digit.

Two chains are cascaded. The first yields the ones digit and a quotient of up to 25. The second splits that quotient into the tens digit and the hundreds digit. The quotient bits are never packed straight into a tens digit, because that bundle can reach ten or more.

The word width is a parameter limited to 7, 8 or 9 bits, so three digits always suffice. The default width of 8 is the intended configuration.

Top module: `bcd_convert`

## Requirements
- R1: A divide-by-five cell given x in 0..9 returns quotient bit floor(x/5) and a 3-bit remainder x mod 5.
- R2: For every value of bin, every cell in the array receives an input of 9 or less.
- R3: Each divide-by-ten chain returns floor(v/10) as its quotient and v mod 10 as its digit, where v is that chain's input.
- R4: ones equals bin mod 10 for every input value.
- R5: tens equals floor(bin/10) mod 10 for every input value.
- R6: hundreds equals floor(bin/100), which is at most 2 in the 8-bit configuration.
- R7: tens and ones never exceed 9, and hundreds*100 + tens*10 + ones equals bin.
- R8: The outputs are a purely combinational function of bin and settle within the same clock period in which bin changes, with no clock edge needed.
- R9: Bit 0 of ones equals bin[0], because that bit bypasses every cell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bin | input | WIDTH (8) | Unsigned binary value to convert |
| hundreds | output | WIDTH-6 (2) | Hundreds digit |
| tens | output | 4 | Tens digit, BCD |
| ones | output | 4 | Ones digit, BCD |

## Verification
The in-cell assertions assume the cell input is never 10 to 15. The cascade has to guarantee this: the first cell of each chain has a zero top bit, and each later input is a remainder of at most 4 shifted up one place. The bench therefore drives only bin and never forces internal nodes. It covers all 256 values, so every reachable cell input is exercised. The assertions skip unknown values, which arise before the bench first drives bin. Random and directed values, including 0, 9, 10, 99, 100, 199, 200 and 255, come on top of the sweep.

// File: rtl/bcd_pkg.sv
package bcd_pkg;

   typedef logic [3:0] bcd_digit_t;

   localparam int unsigned CELL_IN_W  = 4;
   localparam int unsigned CELL_REM_W = 3;
   localparam int unsigned CELL_MAX   = 9;

   // Quotient bits produced by one divide-by-ten chain over an n-bit value.
   function automatic int unsigned chain_quot_w(input int unsigned n);
      return n - 3;
   endfunction

endpackage

// File: rtl/bcd_div5_cell.sv
module bcd_div5_cell
   import bcd_pkg::*;
(
   input  logic [CELL_IN_W-1:0]  x,
   output logic                  q,
   output logic [CELL_REM_W-1:0] r
);

   always_comb begin
      case (x)
         4'd0:    begin q = 1'b0; r = 3'd0; end
         4'd1:    begin q = 1'b0; r = 3'd1; end
         4'd2:    begin q = 1'b0; r = 3'd2; end
         4'd3:    begin q = 1'b0; r = 3'd3; end
         4'd4:    begin q = 1'b0; r = 3'd4; end
         4'd5:    begin q = 1'b1; r = 3'd0; end
         4'd6:    begin q = 1'b1; r = 3'd1; end
         4'd7:    begin q = 1'b1; r = 3'd2; end
         4'd8:    begin q = 1'b1; r = 3'd3; end
         4'd9:    begin q = 1'b1; r = 3'd4; end
         default: begin q = 1'b0; r = 3'd0; end
      endcase
   end

   always_comb begin
      if (!$isunknown(x)) begin
         assert_cell_in_range_R2: assert (x <= 4'(CELL_MAX))
            else $error("cell input %0d exceeds nine", x);
         assert_cell_divides_R1: assert (({3'b000, q} * 4'd5) + {1'b0, r} == x && r <= 3'd4)
            else $error("cell %0d gave q=%0d r=%0d", x, q, r);
      end
   end

endmodule

// File: rtl/bcd_div10_chain.sv
module bcd_div10_chain
   import bcd_pkg::*;
#(
   parameter int unsigned N = 8
)(
   input  logic [N-1:0]              v,
   output logic [chain_quot_w(N)-1:0] quot,
   output bcd_digit_t                digit
);

   localparam int unsigned QW = chain_quot_w(N);
   localparam int unsigned AW = N + 1;

   initial begin
      assert_chain_width_R3: assert (N >= 4)
         else $error("chain needs at least four input bits");
   end

   logic [CELL_REM_W-1:0] part_rem [QW];

   for (genvar k = 0; k < QW; k++) begin : g_cell
      logic [CELL_IN_W-1:0] cell_in;
      if (k == 0) begin : g_head
         assign cell_in = {1'b0, v[N-1:N-3]};
      end else begin : g_link
         assign cell_in = {part_rem[k-1], v[N-3-k]};
      end
      bcd_div5_cell u_cell (
         .x (cell_in),
         .q (quot[QW-1-k]),
         .r (part_rem[k])
      );
   end

   assign digit = {part_rem[QW-1], v[0]};

   logic [AW-1:0] recomposed;
   always_comb recomposed = AW'(quot) * AW'(10) + AW'(digit);

   always_comb begin
      if (!$isunknown(v)) begin
         assert_chain_divides_R3: assert (recomposed == {1'b0, v} && digit <= 4'd9)
            else $error("chain input %0d gave quot %0d digit %0d", v, quot, digit);
      end
   end

endmodule

// File: rtl/bcd_convert.sv
module bcd_convert
   import bcd_pkg::*;
#(
   parameter int unsigned WIDTH = 8
)(
   input  logic [WIDTH-1:0] bin,
   output logic [WIDTH-7:0] hundreds,
   output logic [3:0]       tens,
   output logic [3:0]       ones
);

   localparam int unsigned MID_W  = chain_quot_w(WIDTH);
   localparam int unsigned HUND_W = chain_quot_w(MID_W);
   localparam int unsigned SUM_W  = WIDTH + 4;

   initial begin
      assert_width_range_R6: assert (WIDTH >= 7 && WIDTH <= 9)
         else $error("WIDTH %0d outside 7..9", WIDTH);
   end

   logic [MID_W-1:0]  tens_bin;
   logic [HUND_W-1:0] hund_bin;
   bcd_digit_t        ones_d;
   bcd_digit_t        tens_d;

   bcd_div10_chain #(.N(WIDTH)) u_ones_chain (
      .v     (bin),
      .quot  (tens_bin),
      .digit (ones_d)
   );

   bcd_div10_chain #(.N(MID_W)) u_tens_chain (
      .v     (tens_bin),
      .quot  (hund_bin),
      .digit (tens_d)
   );

   assign ones     = ones_d;
   assign tens     = tens_d;
   assign hundreds = hund_bin;

   logic [SUM_W-1:0] total;
   always_comb total = SUM_W'(hundreds) * SUM_W'(100) + SUM_W'(tens) * SUM_W'(10) + SUM_W'(ones);

   always_comb begin
      if (!$isunknown(bin)) begin
         assert_digits_bcd_R7: assert (tens <= 4'd9 && ones <= 4'd9)
            else $error("digit out of range tens=%0d ones=%0d", tens, ones);
         assert_sum_matches_R7: assert (total == SUM_W'(bin))
            else $error("digits sum %0d, expected %0d", total, bin);
         assert_lsb_bypass_R9: assert (ones[0] == bin[0])
            else $error("ones LSB differs from bin LSB");
      end
   end

endmodule

// File: tb/bcd_convert_tb_top.sv
module bcd_convert_tb_top;

   localparam int unsigned WIDTH = 8;

   logic             clk = 1'b0;
   logic [WIDTH-1:0] bin = '0;
   logic [1:0]       hundreds;
   logic [3:0]       tens;
   logic [3:0]       ones;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   bcd_convert #(.WIDTH(WIDTH)) dut_i (
      .bin      (bin),
      .hundreds (hundreds),
      .tens     (tens),
      .ones     (ones)
   );

   function automatic int exp_ones(input int v);
      return v % 10;
   endfunction
   function automatic int exp_tens(input int v);
      return (v / 10) % 10;
   endfunction
   function automatic int exp_hund(input int v);
      return v / 100;
   endfunction

   task automatic check(input string req, input int act, input int exp, input int v);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s bin=%0d actual=%0d expected=%0d", req, v, act, exp);
      end
   endtask

   // R8: drive just after a rising edge, sample mid-period with no edge between.
   task automatic apply(input int v);
      @(posedge clk);
      #1 bin = WIDTH'(v);
      #1;
      check("R4", int'(ones), exp_ones(v), v);
      check("R5", int'(tens), exp_tens(v), v);
      check("R6", int'(hundreds), exp_hund(v), v);
      check("R9", int'(ones[0]), v % 2, v);
      check("R7", int'(hundreds) * 100 + int'(tens) * 10 + int'(ones), v, v);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

   initial begin : stim
      int unsigned seed;
      int r;
      seed = 32'd1234;
      r = $urandom(seed);
      // Reset state: input zero gives all-zero digits (R4, R5, R6).
      apply(0);
      // Directed corners around digit boundaries (R3, R6).
      apply(9);
      apply(10);
      apply(99);
      apply(100);
      apply(199);
      apply(200);
      apply(255);
      // Exhaustive sweep: every reachable cell input is exercised (R1, R2, R3).
      for (int v = 0; v < 256; v++) apply(v);
      // Random values (R4, R5, R7).
      for (int i = 0; i < 64; i++) begin
         r = int'($urandom() % 256);
         apply(r);
      end
      // R8: back-to-back changes within one period settle without a clock edge.
      @(negedge clk);
      bin = 8'd137;
      #0.5;
      check("R8", int'(hundreds) * 100 + int'(tens) * 10 + int'(ones), 137, 137);
      bin = 8'd58;
      #0.5;
      check("R8", int'(hundreds) * 100 + int'(tens) * 10 + int'(ones), 58, 58);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

endmodule